// File: doc/BRIEF.md
# Load Queue with Memory-Ordering Violation Detection

This block keeps the loads of an out-of-order core in a circular queue in program order. When a store resolves its address, the block checks whether any younger load has already read memory in the same coarse region. Younger means inserted after the store's position in the load queue. The oldest such load is reported as the violator, so the core can squash and refetch from that load. One violator is held at a time. It stays visible until the core reads it, and while it is held, further store checks are skipped.

The core also uses the queue to retire loads in order and to discard speculative loads. Commit pops every leading load whose sequence number is at or below a given bound, in a single cycle. Squash trims every trailing load whose sequence number is above a given bound, also in a single cycle. Squash also clears a stall marker that points at a removed entry, and a blocked-load marker that is younger than the squash point. Dispatch receives the number of free load/store slots, computed from the load occupancy and the store-queue occupancy that the core supplies.

Top module: `lq_order_guard`

## Requirements
- R1: The queue keeps one slot spare and holds at most LQ_DEPTH-1 loads. `lq_full` is high when that many loads are held. An insert while full is ignored and leaves the tail index and the free count unchanged.
- R2: An insert takes the slot shown on `ins_lq_idx`, and the tail then advances by one, modulo LQ_DEPTH. `ins_sq_tag` shows the store-queue tail zero-extended by one bit. When `sq_count` is zero it shows all ones instead, meaning -1.
- R3: A load takes part in ordering checks only after `exe_valid` has recorded an address for its occupied slot. An occupied slot without a recorded address never matches, whatever its stale address bits hold.
- R4: A store check covers the slots from `st_lq_idx` (inclusive) up to the current tail (exclusive), wrapping at LQ_DEPTH. Addresses match when bits ADDR_W-1 down to GRAN_SHIFT are equal; GRAN_SHIFT defaults to 8. If `st_lq_idx` equals the tail, the range is empty.
- R5: Among the matching loads in the range, the one nearest `st_lq_idx` is reported. `viol_pulse` is high for the one cycle after the `st_valid` cycle, with that load's slot on `viol_idx` and its sequence number on `viol_seq`.
- R6: After a report, `viol_held` stays high and `viol_idx`/`viol_seq` stay fixed. During that time, store checks produce no new report. A `viol_read` cycle drops `viol_held` in the next cycle.
- R7: A store whose `st_size` is zero produces no report.
- R8: `cmt_valid` with bound Y removes, in one cycle, every load from the head onward up to the first one whose sequence number exceeds Y.
- R9: `sqh_valid` with bound S removes, in one cycle, every load from the tail backward while its sequence number exceeds S. A set stall whose slot is among the removed ones is cleared. In a squash cycle, insert and commit are ignored, and removed loads no longer take part in store checks.
- R10: A squash with bound S clears the blocked-load marker if the marker's sequence number is greater than S. Otherwise the marker is kept.
- R11: `free_slots` equals min(LQ_DEPTH - loads, SQ_DEPTH - `sq_count`) - 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert a load at the tail |
| ins_seq | input | SEQ_W | Sequence number of the inserted load |
| ins_lq_idx | output | log2(LQ_DEPTH) | Slot the next insert takes |
| ins_sq_tag | output | log2(SQ_DEPTH)+1 | Store-queue tail recorded for the insert, all ones if store queue empty |
| lq_full | output | 1 | Queue holds LQ_DEPTH-1 loads |
| sq_tail | input | log2(SQ_DEPTH) | Current store-queue tail |
| sq_count | input | log2(SQ_DEPTH)+1 | Stores currently held by the store queue |
| exe_valid | input | 1 | A load has produced its address |
| exe_idx | input | log2(LQ_DEPTH) | Slot of that load |
| exe_addr | input | ADDR_W | Address of that load |
| st_valid | input | 1 | A store executes |
| st_lq_idx | input | log2(LQ_DEPTH) | Load-queue tail recorded when the store was inserted |
| st_addr | input | ADDR_W | Store address |
| st_size | input | SIZE_W | Store size in bytes, zero skips the check |
| viol_pulse | output | 1 | New violator captured |
| viol_held | output | 1 | A violator is held |
| viol_idx | output | log2(LQ_DEPTH) | Slot of the held violator |
| viol_seq | output | SEQ_W | Sequence number of the held violator |
| viol_read | input | 1 | Consume the held violator |
| cmt_valid | input | 1 | Commit request |
| cmt_seq | input | SEQ_W | Youngest sequence number to commit |
| sqh_valid | input | 1 | Squash request |
| sqh_seq | input | SEQ_W | Sequence number kept by the squash |
| stall_set | input | 1 | Mark a load slot as stalled |
| stall_idx | input | log2(LQ_DEPTH) | Slot of the stalled load |
| stall_active | output | 1 | Stall marker set |
| blk_set | input | 1 | Mark a blocked load |
| blk_seq | input | SEQ_W | Sequence number of the blocked load |
| blk_active | output | 1 | Blocked-load marker set |
| free_slots | output | max(log2 LQ,log2 SQ)+1 | Free load/store slots for dispatch |

## Verification
The bench uses the defaults: eight load slots, eight store slots, a 256-byte granule, 32-bit addresses and 16-bit sequence numbers. With eight slots, a few inserts are enough to fill the queue and wrap the tail past zero. A store check can then span the wrap boundary and pick the older of two matches on either side of it. Squash and commit can also remove several entries in one cycle. The small store depth lets `sq_count` make the store side the limiting term in the free count. The 256-byte granule lets nearby addresses fall on either side of a region boundary.

// File: rtl/lqg_pkg.sv
package lqg_pkg;
   typedef enum logic {
      WALK_FWD = 1'b0,
      WALK_BWD = 1'b1
   } walk_dir_e;
endpackage

// File: rtl/lqg_walk.sv
// Measures the run of leading (forward) or trailing (backward) occupied slots
// that satisfy the sequence bound; used for commit and for squash.
module lqg_walk
   import lqg_pkg::*;
#(
   parameter int        DEPTH = 8,
   parameter int        SEQ_W = 16,
   parameter walk_dir_e DIR   = WALK_FWD,
   localparam int       PW    = $clog2(DEPTH)
) (
   input  logic [PW-1:0]    base,
   input  logic [PW:0]      occ,
   input  logic [SEQ_W-1:0] seq_arr [DEPTH],
   input  logic [SEQ_W-1:0] bound,
   output logic [PW:0]      run
);
   generate
      if (DIR == WALK_FWD) begin : g_fwd
         always_comb begin
            logic          live;
            logic [PW-1:0] idx;
            run  = '0;
            live = 1'b1;
            for (int k = 0; k < DEPTH; k++) begin
               idx = base + PW'(k);
               if (live && (k < int'(occ)) && (seq_arr[idx] <= bound))
                  run = run + (PW+1)'(1);
               else
                  live = 1'b0;
            end
         end
      end else begin : g_bwd
         always_comb begin
            logic          live;
            logic [PW-1:0] idx;
            run  = '0;
            live = 1'b1;
            for (int k = 0; k < DEPTH; k++) begin
               idx = base - PW'(k) - PW'(1);
               if (live && (k < int'(occ)) && (seq_arr[idx] > bound))
                  run = run + (PW+1)'(1);
               else
                  live = 1'b0;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/lqg_scan.sv
// Age-ordered search from a start slot up to the tail: the first executed
// load whose granule equals the key granule wins.
module lqg_scan #(
   parameter int  DEPTH      = 8,
   parameter int  ADDR_W     = 32,
   parameter int  GRAN_SHIFT = 8,
   localparam int PW         = $clog2(DEPTH)
) (
   input  logic [PW-1:0]     start,
   input  logic [PW-1:0]     tail,
   input  logic              vld      [DEPTH],
   input  logic              aval     [DEPTH],
   input  logic [ADDR_W-1:0] addr_arr [DEPTH],
   input  logic [ADDR_W-1:0] key,
   output logic              hit,
   output logic [PW-1:0]     hit_idx
);
   logic [PW-1:0] span;
   assign span = tail - start;

   always_comb begin
      logic [PW-1:0] idx;
      hit     = 1'b0;
      hit_idx = '0;
      for (int k = 0; k < DEPTH; k++) begin
         idx = start + PW'(k);
         if (!hit && (PW'(k) < span) && vld[idx] && aval[idx] &&
             (addr_arr[idx][ADDR_W-1:GRAN_SHIFT] == key[ADDR_W-1:GRAN_SHIFT])) begin
            hit     = 1'b1;
            hit_idx = idx;
         end
      end
   end
endmodule

// File: rtl/lqg_viol_reg.sv
// Single sticky violator register with a capture pulse.
module lqg_viol_reg #(
   parameter int PW    = 3,
   parameter int SEQ_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture,
   input  logic [PW-1:0]    cap_idx,
   input  logic [SEQ_W-1:0] cap_seq,
   input  logic             rd,
   output logic             pulse,
   output logic             held,
   output logic [PW-1:0]    idx,
   output logic [SEQ_W-1:0] seq
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pulse <= 1'b0;
         held  <= 1'b0;
         idx   <= '0;
         seq   <= '0;
      end else begin
         pulse <= capture;
         if (capture) begin
            held <= 1'b1;
            idx  <= cap_idx;
            seq  <= cap_seq;
         end else if (rd) begin
            held <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/lq_order_guard.sv
module lq_order_guard
   import lqg_pkg::*;
#(
   parameter int  LQ_DEPTH   = 8,
   parameter int  SQ_DEPTH   = 8,
   parameter int  ADDR_W     = 32,
   parameter int  SEQ_W      = 16,
   parameter int  SIZE_W     = 4,
   parameter int  GRAN_SHIFT = 8,
   localparam int LPW        = $clog2(LQ_DEPTH),
   localparam int SPW        = $clog2(SQ_DEPTH),
   localparam int FREE_W     = ((LPW > SPW) ? LPW : SPW) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ins_valid,
   input  logic [SEQ_W-1:0]  ins_seq,
   output logic [LPW-1:0]    ins_lq_idx,
   output logic [SPW:0]      ins_sq_tag,
   output logic              lq_full,
   input  logic [SPW-1:0]    sq_tail,
   input  logic [SPW:0]      sq_count,
   input  logic              exe_valid,
   input  logic [LPW-1:0]    exe_idx,
   input  logic [ADDR_W-1:0] exe_addr,
   input  logic              st_valid,
   input  logic [LPW-1:0]    st_lq_idx,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic [SIZE_W-1:0] st_size,
   output logic              viol_pulse,
   output logic              viol_held,
   output logic [LPW-1:0]    viol_idx,
   output logic [SEQ_W-1:0]  viol_seq,
   input  logic              viol_read,
   input  logic              cmt_valid,
   input  logic [SEQ_W-1:0]  cmt_seq,
   input  logic              sqh_valid,
   input  logic [SEQ_W-1:0]  sqh_seq,
   input  logic              stall_set,
   input  logic [LPW-1:0]    stall_idx,
   output logic              stall_active,
   input  logic              blk_set,
   input  logic [SEQ_W-1:0]  blk_seq,
   output logic              blk_active,
   output logic [FREE_W-1:0] free_slots
);
   // elaboration-time parameter checks
   if (LQ_DEPTH < 2 || (LQ_DEPTH & (LQ_DEPTH - 1)) != 0) begin : g_bad_lq
      $error("LQ_DEPTH must be a power of two, at least 2");
   end
   if (SQ_DEPTH < 2 || (SQ_DEPTH & (SQ_DEPTH - 1)) != 0) begin : g_bad_sq
      $error("SQ_DEPTH must be a power of two, at least 2");
   end
   if (GRAN_SHIFT < 0 || GRAN_SHIFT >= ADDR_W) begin : g_bad_gran
      $error("GRAN_SHIFT must lie inside the address");
   end

   localparam logic [LPW:0] MAX_LOADS = (LPW+1)'(LQ_DEPTH - 1);

   logic [LPW-1:0]    head_q, tail_q;
   logic [LPW:0]      load_cnt;
   logic              ent_vld  [LQ_DEPTH];
   logic              ent_aval [LQ_DEPTH];
   logic [SEQ_W-1:0]  ent_seq  [LQ_DEPTH];
   logic [ADDR_W-1:0] ent_addr [LQ_DEPTH];

   logic              ins_go, cmt_go;
   logic [LPW:0]      cmt_run, sqh_run;
   logic              scan_hit;
   logic [LPW-1:0]    scan_idx;
   logic              capture;

   assign lq_full    = (load_cnt == MAX_LOADS);
   assign ins_go     = ins_valid && !lq_full && !sqh_valid;
   assign cmt_go     = cmt_valid && !sqh_valid;
   assign ins_lq_idx = tail_q;
   assign ins_sq_tag = (sq_count == '0) ? '1 : {1'b0, sq_tail};

   // commit run from the head, squash run from the tail
   lqg_walk #(.DEPTH(LQ_DEPTH), .SEQ_W(SEQ_W), .DIR(WALK_FWD)) u_cmt_walk (
      .base(head_q), .occ(load_cnt), .seq_arr(ent_seq), .bound(cmt_seq), .run(cmt_run)
   );
   lqg_walk #(.DEPTH(LQ_DEPTH), .SEQ_W(SEQ_W), .DIR(WALK_BWD)) u_sqh_walk (
      .base(tail_q), .occ(load_cnt), .seq_arr(ent_seq), .bound(sqh_seq), .run(sqh_run)
   );

   // per-slot storage
   for (genvar i = 0; i < LQ_DEPTH; i++) begin : g_ent
      logic              vld_q, aval_q;
      logic [SEQ_W-1:0]  seq_q;
      logic [ADDR_W-1:0] addr_q;
      logic [LPW-1:0]    off_h, off_t;
      logic              rm, put, rec;

      assign off_h = LPW'(i) - head_q;
      assign off_t = tail_q - LPW'(1) - LPW'(i);
      assign rm    = (cmt_go && ({1'b0, off_h} < cmt_run)) ||
                     (sqh_valid && ({1'b0, off_t} < sqh_run));
      assign put   = ins_go && (tail_q == LPW'(i));
      assign rec   = exe_valid && (exe_idx == LPW'(i)) && vld_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q  <= 1'b0;
            aval_q <= 1'b0;
            seq_q  <= '0;
            addr_q <= '0;
         end else if (rm) begin
            vld_q  <= 1'b0;
            aval_q <= 1'b0;
         end else if (put) begin
            vld_q  <= 1'b1;
            aval_q <= 1'b0;
            seq_q  <= ins_seq;
         end else if (rec) begin
            aval_q <= 1'b1;
            addr_q <= exe_addr;
         end
      end

      assign ent_vld[i]  = vld_q;
      assign ent_aval[i] = aval_q;
      assign ent_seq[i]  = seq_q;
      assign ent_addr[i] = addr_q;
   end

   // pointers and occupancy
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q   <= '0;
         tail_q   <= '0;
         load_cnt <= '0;
      end else if (sqh_valid) begin
         tail_q   <= tail_q - LPW'(sqh_run);
         load_cnt <= load_cnt - sqh_run;
      end else begin
         if (cmt_go)
            head_q <= head_q + LPW'(cmt_run);
         if (ins_go)
            tail_q <= tail_q + LPW'(1);
         load_cnt <= load_cnt - (cmt_go ? cmt_run : '0) + {{LPW{1'b0}}, ins_go};
      end
   end

   // ordering check
   lqg_scan #(.DEPTH(LQ_DEPTH), .ADDR_W(ADDR_W), .GRAN_SHIFT(GRAN_SHIFT)) u_scan (
      .start(st_lq_idx), .tail(tail_q), .vld(ent_vld), .aval(ent_aval),
      .addr_arr(ent_addr), .key(st_addr), .hit(scan_hit), .hit_idx(scan_idx)
   );

   assign capture = st_valid && !viol_held && (st_size != '0) && scan_hit;

   lqg_viol_reg #(.PW(LPW), .SEQ_W(SEQ_W)) u_viol (
      .clk(clk), .rst_n(rst_n), .capture(capture), .cap_idx(scan_idx),
      .cap_seq(ent_seq[scan_idx]), .rd(viol_read), .pulse(viol_pulse),
      .held(viol_held), .idx(viol_idx), .seq(viol_seq)
   );

   // stall and blocked-load markers
   logic [LPW-1:0]   stall_idx_q;
   logic [SEQ_W-1:0] blk_seq_q;
   logic [LPW-1:0]   stall_off;
   assign stall_off = tail_q - LPW'(1) - stall_idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stall_active <= 1'b0;
         stall_idx_q  <= '0;
         blk_active   <= 1'b0;
         blk_seq_q    <= '0;
      end else begin
         if (stall_set) begin
            stall_active <= 1'b1;
            stall_idx_q  <= stall_idx;
         end else if (sqh_valid && ({1'b0, stall_off} < sqh_run)) begin
            stall_active <= 1'b0;
         end
         if (blk_set) begin
            blk_active <= 1'b1;
            blk_seq_q  <= blk_seq;
         end else if (sqh_valid && (sqh_seq < blk_seq_q)) begin
            blk_active <= 1'b0;
         end
      end
   end

   // free slots for dispatch
   always_comb begin
      logic [FREE_W:0] lq_room, sq_room;
      lq_room    = (FREE_W+1)'(LQ_DEPTH) - (FREE_W+1)'(load_cnt);
      sq_room    = (FREE_W+1)'(SQ_DEPTH) - (FREE_W+1)'(sq_count);
      free_slots = FREE_W'(((lq_room < sq_room) ? lq_room : sq_room) - (FREE_W+1)'(1));
   end
endmodule

// File: rtl/lqg_checker.sv
module lqg_checker #(
   parameter int LQ_DEPTH = 8,
   parameter int LPW      = 3,
   parameter int SIZE_W   = 4,
   parameter int FREE_W   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lq_full,
   input logic              ins_valid,
   input logic              cmt_valid,
   input logic              sqh_valid,
   input logic [LPW:0]      load_cnt,
   input logic [FREE_W-1:0] free_slots,
   input logic              st_valid,
   input logic [SIZE_W-1:0] st_size,
   input logic              viol_pulse,
   input logic              viol_held,
   input logic [LPW-1:0]    viol_idx,
   input logic              viol_read
);
   p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      int'(load_cnt) <= LQ_DEPTH - 1);

   p_full_ignores_insert_r1: assert property (@(posedge clk) disable iff (!rst_n)
      lq_full && ins_valid && !cmt_valid && !sqh_valid |=> $stable(load_cnt));

   p_pulse_from_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
      viol_pulse |-> $past(st_valid) && !$past(viol_held) && ($past(st_size) != '0));

   p_pulse_sets_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      viol_pulse |-> viol_held);

   p_hold_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      viol_held && !viol_read |=> viol_held && $stable(viol_idx) && !viol_pulse);

   p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      viol_held && viol_read |=> !viol_held);

   p_zero_size_skips_r7: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid && (st_size == '0) |=> !viol_pulse);

   p_free_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
      int'(free_slots) <= LQ_DEPTH - 1 - int'(load_cnt));
endmodule

bind lq_order_guard lqg_checker #(
   .LQ_DEPTH(LQ_DEPTH), .LPW(LPW), .SIZE_W(SIZE_W), .FREE_W(FREE_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .lq_full(lq_full), .ins_valid(ins_valid),
   .cmt_valid(cmt_valid), .sqh_valid(sqh_valid), .load_cnt(load_cnt),
   .free_slots(free_slots), .st_valid(st_valid), .st_size(st_size),
   .viol_pulse(viol_pulse), .viol_held(viol_held), .viol_idx(viol_idx),
   .viol_read(viol_read)
);

// File: tb/tb_lq_order_guard.sv
module tb_lq_order_guard;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ins_valid = 1'b0;
   logic [15:0] ins_seq = '0;
   logic [2:0]  ins_lq_idx;
   logic [3:0]  ins_sq_tag;
   logic        lq_full;
   logic [2:0]  sq_tail = '0;
   logic [3:0]  sq_count = '0;
   logic        exe_valid = 1'b0;
   logic [2:0]  exe_idx = '0;
   logic [31:0] exe_addr = '0;
   logic        st_valid = 1'b0;
   logic [2:0]  st_lq_idx = '0;
   logic [31:0] st_addr = '0;
   logic [3:0]  st_size = '0;
   logic        viol_pulse, viol_held;
   logic [2:0]  viol_idx;
   logic [15:0] viol_seq;
   logic        viol_read = 1'b0;
   logic        cmt_valid = 1'b0;
   logic [15:0] cmt_seq = '0;
   logic        sqh_valid = 1'b0;
   logic [15:0] sqh_seq = '0;
   logic        stall_set = 1'b0;
   logic [2:0]  stall_idx = '0;
   logic        stall_active;
   logic        blk_set = 1'b0;
   logic [15:0] blk_seq = '0;
   logic        blk_active;
   logic [3:0]  free_slots;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   lq_order_guard dut (
      .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_seq(ins_seq),
      .ins_lq_idx(ins_lq_idx), .ins_sq_tag(ins_sq_tag), .lq_full(lq_full),
      .sq_tail(sq_tail), .sq_count(sq_count), .exe_valid(exe_valid),
      .exe_idx(exe_idx), .exe_addr(exe_addr), .st_valid(st_valid),
      .st_lq_idx(st_lq_idx), .st_addr(st_addr), .st_size(st_size),
      .viol_pulse(viol_pulse), .viol_held(viol_held), .viol_idx(viol_idx),
      .viol_seq(viol_seq), .viol_read(viol_read), .cmt_valid(cmt_valid),
      .cmt_seq(cmt_seq), .sqh_valid(sqh_valid), .sqh_seq(sqh_seq),
      .stall_set(stall_set), .stall_idx(stall_idx), .stall_active(stall_active),
      .blk_set(blk_set), .blk_seq(blk_seq), .blk_active(blk_active),
      .free_slots(free_slots)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic ins(input logic [15:0] s);
      ins_valid = 1'b1; ins_seq = s;
      step();
      ins_valid = 1'b0;
   endtask

   task automatic exe(input logic [2:0] i, input logic [31:0] a);
      exe_valid = 1'b1; exe_idx = i; exe_addr = a;
      step();
      exe_valid = 1'b0;
   endtask

   task automatic store(input logic [2:0] i, input logic [31:0] a, input logic [3:0] sz,
                        output logic p, output logic [2:0] vi, output logic [15:0] vs);
      st_valid = 1'b1; st_lq_idx = i; st_addr = a; st_size = sz;
      step();
      st_valid = 1'b0;
      p = viol_pulse; vi = viol_idx; vs = viol_seq;
      step();
   endtask

   task automatic rd();
      viol_read = 1'b1;
      step();
      viol_read = 1'b0;
   endtask

   task automatic commit(input logic [15:0] y);
      cmt_valid = 1'b1; cmt_seq = y;
      step();
      cmt_valid = 1'b0;
   endtask

   task automatic squash(input logic [15:0] s);
      sqh_valid = 1'b1; sqh_seq = s;
      step();
      sqh_valid = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1", "full after reset", lq_full, 0);
      chk("R11", "free after reset", free_slots, 7);
      chk("R6", "held after reset", viol_held, 0);
      chk("R5", "pulse after reset", viol_pulse, 0);
      chk("R2", "tail after reset", ins_lq_idx, 0);
      chk("R2", "sq tag empty", ins_sq_tag, 4'hF);
   endtask

   task automatic t_insert();
      chk("R2", "slot 0", ins_lq_idx, 0);
      ins(16'd10);
      chk("R2", "slot 1", ins_lq_idx, 1);
      ins(16'd11);
      ins(16'd12);
      chk("R2", "slot 3", ins_lq_idx, 3);
      chk("R11", "free three loads", free_slots, 4);
      sq_count = 4'd2; sq_tail = 3'd5;
      #1;
      chk("R2", "sq tag live", ins_sq_tag, 4'h5);
      sq_count = 4'd0;
      #1;
   endtask

   task automatic t_violation();
      logic p; logic [2:0] vi; logic [15:0] vs;
      exe(3'd1, 32'h1234);
      exe(3'd2, 32'h1250);
      store(3'd0, 32'h12FF, 4'd4, p, vi, vs);
      chk("R5", "pulse", p, 1);
      chk("R5", "violator slot oldest", vi, 1);
      chk("R5", "violator seq", vs, 11);
      chk("R6", "held after pulse gone", viol_held, 1);
      store(3'd2, 32'h1250, 4'd4, p, vi, vs);
      chk("R6", "no pulse while held", p, 0);
      chk("R6", "held slot unchanged", vi, 1);
      rd();
      chk("R6", "read clears", viol_held, 0);
      store(3'd2, 32'h12AA, 4'd4, p, vi, vs);
      chk("R4", "start excludes older", vi, 2);
      chk("R4", "start pulse", p, 1);
      chk("R4", "start seq", vs, 12);
      rd();
   endtask

   task automatic t_skips();
      logic p; logic [2:0] vi; logic [15:0] vs;
      store(3'd0, 32'h12FF, 4'd0, p, vi, vs);
      chk("R7", "size zero no report", p, 0);
      store(3'd0, 32'h1300, 4'd4, p, vi, vs);
      chk("R4", "other granule no report", p, 0);
      store(3'd3, 32'h1234, 4'd4, p, vi, vs);
      chk("R4", "empty range no report", p, 0);
      store(3'd0, 32'h0000, 4'd4, p, vi, vs);
      chk("R3", "unexecuted load ignored", p, 0);
      chk("R3", "nothing held", viol_held, 0);
   endtask

   task automatic t_commit();
      commit(16'd11);
      chk("R8", "two popped", free_slots, 6);
      commit(16'd9);
      chk("R8", "head too young", free_slots, 6);
   endtask

   task automatic t_wrap();
      logic p; logic [2:0] vi; logic [15:0] vs;
      for (int k = 0; k < 6; k++) ins(16'(20 + k));
      chk("R1", "full", lq_full, 1);
      chk("R1", "free zero", free_slots, 0);
      chk("R2", "tail wrapped", ins_lq_idx, 1);
      ins(16'd26);
      chk("R1", "insert when full ignored", ins_lq_idx, 1);
      chk("R1", "free still zero", free_slots, 0);
      exe(3'd7, 32'h4400);
      exe(3'd0, 32'h4410);
      exe(3'd5, 32'h5500);
      store(3'd6, 32'h44F0, 4'd8, p, vi, vs);
      chk("R5", "wrap oldest slot", vi, 7);
      chk("R5", "wrap oldest seq", vs, 24);
      chk("R4", "wrap pulse", p, 1);
      rd();
   endtask

   task automatic t_squash();
      logic p; logic [2:0] vi; logic [15:0] vs;
      stall_set = 1'b1; stall_idx = 3'd7; blk_set = 1'b1; blk_seq = 16'd23;
      step();
      stall_set = 1'b0; blk_set = 1'b0;
      chk("R9", "stall set", stall_active, 1);
      squash(16'd22);
      chk("R9", "three removed", free_slots, 3);
      chk("R9", "tail moved back", ins_lq_idx, 6);
      chk("R9", "stall on removed slot cleared", stall_active, 0);
      chk("R10", "younger block cleared", blk_active, 0);
      stall_set = 1'b1; stall_idx = 3'd2; blk_set = 1'b1; blk_seq = 16'd20;
      step();
      stall_set = 1'b0; blk_set = 1'b0;
      squash(16'd21);
      chk("R9", "one removed", free_slots, 4);
      chk("R9", "tail at 5", ins_lq_idx, 5);
      chk("R9", "stall on kept slot stays", stall_active, 1);
      chk("R10", "older block kept", blk_active, 1);
      ins_valid = 1'b1; ins_seq = 16'd40; sqh_valid = 1'b1; sqh_seq = 16'd100;
      step();
      ins_valid = 1'b0; sqh_valid = 1'b0;
      chk("R9", "insert ignored in squash", ins_lq_idx, 5);
      chk("R9", "count unchanged", free_slots, 4);
      store(3'd2, 32'h5500, 4'd4, p, vi, vs);
      chk("R9", "removed load not checked", p, 0);
   endtask

   task automatic t_free();
      sq_count = 4'd6;
      #1;
      chk("R11", "store side limits", free_slots, 1);
      sq_count = 4'd7;
      #1;
      chk("R11", "store side zero", free_slots, 0);
      sq_count = 4'd0;
      #1;
      commit(16'd1000);
      chk("R8", "all popped in one cycle", free_slots, 7);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      step();
      t_reset();
      t_insert();
      t_violation();
      t_skips();
      t_commit();
      t_wrap();
      t_squash();
      t_free();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule